// File: doc/BRIEF.md
# Prioritised Vectored Bus Interrupter

This block raises a backplane interrupt for four local event sources: the timer and the port event of each of two parallel-interface units. A 3-bit strap picks which of seven active-low request lines is driven. Strap value 0 (every jumper fitted) switches the interrupter off completely. The request line is level-style and stays asserted while any source request is high.

When the bus master runs an interrupt acknowledge cycle, the block looks at the daisy-chain input, the acknowledge line, the data strobe and the three level address bits. If the cycle is for its own level and a source is pending, the block responds. It picks the highest-priority pending source and freezes that choice. It then drives that source's 8-bit status/ID byte and asserts the transfer acknowledge. It also pulses a one-hot grant back to the chosen source so that the source can clear its request. Each source supplies its own vector byte. A port unit can change that byte according to which of its port conditions fired, which allows ten distinct vectors across the module. In every other case the block passes the acknowledge down the daisy chain.

All bus inputs are taken as already synchronised to `clk`. Reset is synchronous and active high.

Top module: `vme_intr_vec`

## Requirements
- R1: With strap value 0, every line of `irq_n` stays high whatever `src_req` holds, and every acknowledge cycle is passed on through `iackout_n`.
- R2: With strap value k in 1..7 and any bit of `src_req` high, bit k-1 of `irq_n` is low one clock later and all other bits are high. Only one line is ever low.
- R3: One clock after `src_req` becomes all zero, every bit of `irq_n` is high again.
- R4: The block responds when it samples all of the following: `iackin_n` low, `ds0_n` low, `iack_n` low, `lvl_addr` equal to a nonzero strap, and at least one request pending. In the next cycle `data_oe` is high and `data_out` carries the chosen source's byte from `src_vec`, which holds source i in bits [8i+7:8i]. While `data_oe` is low, `data_out` is 0.
- R5: Priority is fixed by request bit: bit 0 (timer of unit 1), then bit 1 (timer of unit 2), then bit 2 (port of unit 1), then bit 3 (port of unit 2). The choice and its byte are latched at the start of the response. Later changes to `src_req` or `src_vec` do not alter `data_out`.
- R6: `dtack_n` goes low two clocks after the start of the response and stays low while `ds0_n` stays low. It goes high, together with `data_oe` going low, one clock after `ds0_n` is seen high.
- R7: `grant` carries a one-clock one-hot pulse for the chosen source in the first cycle in which the vector is driven, and is zero otherwise.
- R8: When a sampled acknowledge is not for this block, `iackout_n` is low from the next clock and stays low while `iackin_n` stays low. It returns high one clock after `iackin_n` is high. `data_oe` and `dtack_n` stay inactive throughout.
- R9: After a response, `iackout_n` stays high, and no new response starts until `iackin_n` has been high. A second strobe within the same cycle does not produce `dtack_n` or `data_oe`.
- R10: During and right after reset, `irq_n` is all ones, `iackout_n` and `dtack_n` are high, `data_oe` is low and `grant` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 3 | Level strap; 0 disables, 1..7 select the line |
| src_req | input | 4 | Source requests, bit 0 highest priority |
| src_vec | input | 32 | Status/ID byte per source, source i at [8i+7:8i] |
| iack_n | input | 1 | Bus acknowledge-cycle indicator, active low |
| iackin_n | input | 1 | Daisy-chain acknowledge input, active low |
| ds0_n | input | 1 | Low data strobe, active low |
| lvl_addr | input | 3 | Address bits 3..1, the level being acknowledged |
| irq_n | output | 7 | Request lines, bit k is level k+1, active low |
| iackout_n | output | 1 | Daisy-chain acknowledge output, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| data_oe | output | 1 | Enable for the vector onto the data lines |
| data_out | output | 8 | Vector byte |
| grant | output | 4 | One-hot acknowledge pulse back to the sources |

## Verification
Two things can meet in one clock: the request inputs change while the block is already serving an acknowledge, and the choice of winner is made against those same requests. The bench changes `src_req` to all ones and rewrites every vector byte in the cycle right after the response starts. A correct block still drives the byte of the source that won at the start, and the bench expects exactly that byte. A sweep over every strap value, request pattern and acknowledged level works out the expected winner, line and chain outcome arithmetically from the bit positions.

// File: rtl/vme_intr_pkg.sv
package vme_intr_pkg;

    localparam int SRC_N = 4;
    localparam int VEC_W = 8;
    localparam int LVL_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_ACK,
        ST_DONE,
        ST_PASS
    } ack_state_e;

    typedef struct packed {
        logic             valid;
        logic [SRC_N-1:0] onehot;
    } pick_t;

    // lowest set bit wins
    function automatic pick_t pick_first(input logic [SRC_N-1:0] req);
        pick_t p;
        p.valid  = 1'b0;
        p.onehot = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (req[i]) begin
                p.valid  = 1'b1;
                p.onehot = '0;
                p.onehot[i] = 1'b1;
            end
        end
        return p;
    endfunction

    function automatic logic level_hit(input logic [LVL_W-1:0] strap,
                                       input logic [LVL_W-1:0] addr);
        return (strap != '0) && (addr == strap);
    endfunction

endpackage

// File: rtl/vme_irq_lines.sv
module vme_irq_lines #(
    parameter int LVL_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LVL_W-1:0]         strap,
    input  logic                     any_req,
    output logic [(1<<LVL_W)-2:0]    irq_n
);
    localparam int LINES = (1 << LVL_W) - 1;

    for (genvar k = 0; k < LINES; k++) begin : g_line
        logic line_q;
        always_ff @(posedge clk) begin
            if (rst) line_q <= 1'b1;
            else     line_q <= !(any_req && (strap == LVL_W'(k + 1)));
        end
        assign irq_n[k] = line_q;
    end
endmodule

// File: rtl/vme_src_pick.sv
module vme_src_pick
    import vme_intr_pkg::*;
#(
    parameter int VEC_W_P = VEC_W
) (
    input  logic [SRC_N-1:0]          req,
    input  logic [SRC_N*VEC_W_P-1:0]  vec_flat,
    output logic                      valid,
    output logic [SRC_N-1:0]          onehot,
    output logic [VEC_W_P-1:0]        vec
);
    pick_t p;
    logic [VEC_W_P-1:0] masked [SRC_N];

    always_comb p = pick_first(req);

    assign valid  = p.valid;
    assign onehot = p.onehot;

    for (genvar i = 0; i < SRC_N; i++) begin : g_mask
        assign masked[i] = p.onehot[i] ? vec_flat[i*VEC_W_P +: VEC_W_P] : '0;
    end

    always_comb begin
        vec = '0;
        for (int i = 0; i < SRC_N; i++) vec = vec | masked[i];
    end
endmodule

// File: rtl/vme_ack_seq.sv
module vme_ack_seq
    import vme_intr_pkg::*;
#(
    parameter int VEC_W_P = VEC_W,
    parameter int LVL_W_P = LVL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LVL_W_P-1:0]   strap,
    input  logic [LVL_W_P-1:0]   lvl_addr,
    input  logic                 iack_n,
    input  logic                 iackin_n,
    input  logic                 ds0_n,
    input  logic                 pick_valid,
    input  logic [SRC_N-1:0]     pick_onehot,
    input  logic [VEC_W_P-1:0]   pick_vec,
    output logic                 iackout_n,
    output logic                 dtack_n,
    output logic                 data_oe,
    output logic [VEC_W_P-1:0]   data_out,
    output logic [SRC_N-1:0]     grant
);
    ack_state_e          state_q, state_d;
    logic [SRC_N-1:0]    sel_q;
    logic [VEC_W_P-1:0]  vec_q;
    logic                take;
    logic                start;

    assign start = !iackin_n && !ds0_n;
    assign take  = start && !iack_n && pick_valid &&
                   level_hit(LVL_W'(strap), LVL_W'(lvl_addr));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = take ? ST_DRIVE : ST_PASS;
            ST_DRIVE: state_d = ST_ACK;
            ST_ACK:   if (ds0_n) state_d = ST_DONE;
            ST_DONE:  if (iackin_n) state_d = ST_IDLE;
            ST_PASS:  if (iackin_n) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && take) begin
                sel_q <= pick_onehot;
                vec_q <= pick_vec;
            end
        end
    end

    assign iackout_n = (state_q != ST_PASS);
    assign dtack_n   = (state_q != ST_ACK);
    assign data_oe   = (state_q == ST_DRIVE) || (state_q == ST_ACK);
    assign data_out  = data_oe ? vec_q : '0;
    assign grant     = (state_q == ST_DRIVE) ? sel_q : '0;
endmodule

// File: rtl/vme_intr_vec.sv
module vme_intr_vec
    import vme_intr_pkg::*;
#(
    parameter int VEC_W_P = VEC_W,
    parameter int LVL_W_P = LVL_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LVL_W_P-1:0]           strap,
    input  logic [SRC_N-1:0]             src_req,
    input  logic [SRC_N*VEC_W_P-1:0]     src_vec,
    input  logic                         iack_n,
    input  logic                         iackin_n,
    input  logic                         ds0_n,
    input  logic [LVL_W_P-1:0]           lvl_addr,
    output logic [(1<<LVL_W_P)-2:0]      irq_n,
    output logic                         iackout_n,
    output logic                         dtack_n,
    output logic                         data_oe,
    output logic [VEC_W_P-1:0]           data_out,
    output logic [SRC_N-1:0]             grant
);
    logic                pick_valid;
    logic [SRC_N-1:0]    pick_onehot;
    logic [VEC_W_P-1:0]  pick_vec;

    vme_irq_lines #(.LVL_W(LVL_W_P)) u_lines (
        .clk     (clk),
        .rst     (rst),
        .strap   (strap),
        .any_req (|src_req),
        .irq_n   (irq_n)
    );

    vme_src_pick #(.VEC_W_P(VEC_W_P)) u_pick (
        .req      (src_req),
        .vec_flat (src_vec),
        .valid    (pick_valid),
        .onehot   (pick_onehot),
        .vec      (pick_vec)
    );

    vme_ack_seq #(.VEC_W_P(VEC_W_P), .LVL_W_P(LVL_W_P)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .strap       (strap),
        .lvl_addr    (lvl_addr),
        .iack_n      (iack_n),
        .iackin_n    (iackin_n),
        .ds0_n       (ds0_n),
        .pick_valid  (pick_valid),
        .pick_onehot (pick_onehot),
        .pick_vec    (pick_vec),
        .iackout_n   (iackout_n),
        .dtack_n     (dtack_n),
        .data_oe     (data_oe),
        .data_out    (data_out),
        .grant       (grant)
    );
endmodule

// File: rtl/vme_intr_vec_chk.sv
module vme_intr_vec_chk #(
    parameter int VEC_W_P = 8,
    parameter int LVL_W_P = 3,
    parameter int SRC_N_P = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [LVL_W_P-1:0]         strap,
    input logic                       ds0_n,
    input logic                       iackin_n,
    input logic [(1<<LVL_W_P)-2:0]    irq_n,
    input logic                       iackout_n,
    input logic                       dtack_n,
    input logic                       data_oe,
    input logic [VEC_W_P-1:0]         data_out,
    input logic [SRC_N_P-1:0]         grant
);
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (strap == '0 && $past(strap) == '0) |-> (&irq_n));

    p_single_line_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(~irq_n) <= 1);

    p_vec_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (data_oe && $past(data_oe)) |-> $stable(data_out));

    p_dtack_with_vec_r6: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> data_oe);

    p_dtack_release_r6: assert property (@(posedge clk) disable iff (rst)
        (!dtack_n && ds0_n) |=> dtack_n);

    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_pass_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(!iackout_n && data_oe));

    p_pass_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!iackout_n && !iackin_n) |=> !iackout_n);
endmodule

bind vme_intr_vec vme_intr_vec_chk #(
    .VEC_W_P (VEC_W_P),
    .LVL_W_P (LVL_W_P),
    .SRC_N_P (vme_intr_pkg::SRC_N)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .strap     (strap),
    .ds0_n     (ds0_n),
    .iackin_n  (iackin_n),
    .irq_n     (irq_n),
    .iackout_n (iackout_n),
    .dtack_n   (dtack_n),
    .data_oe   (data_oe),
    .data_out  (data_out),
    .grant     (grant)
);

// File: tb/vme_intr_vec_test.sv
`timescale 1ns/1ps
module vme_intr_vec_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  strap;
    logic [3:0]  src_req;
    logic [31:0] src_vec;
    logic        iack_n, iackin_n, ds0_n;
    logic [2:0]  lvl_addr;
    logic [6:0]  irq_n;
    logic        iackout_n, dtack_n, data_oe;
    logic [7:0]  data_out;
    logic [3:0]  grant;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    vme_intr_vec uut (
        .clk(clk), .rst(rst), .strap(strap), .src_req(src_req), .src_vec(src_vec),
        .iack_n(iack_n), .iackin_n(iackin_n), .ds0_n(ds0_n), .lvl_addr(lvl_addr),
        .irq_n(irq_n), .iackout_n(iackout_n), .dtack_n(dtack_n), .data_oe(data_oe),
        .data_out(data_out), .grant(grant)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [7:0] vbyte(input int l, input int r, input int i);
        return 8'((l * 16 + r * 4 + i * 37 + 8'h11) & 8'hFF);
    endfunction

    task automatic run_one(input int l, input int r, input int a);
        int          win;
        bit          resp;
        logic [6:0]  exp_irq;
        logic [7:0]  exp_vec;
        logic [3:0]  exp_g;
        win = -1;
        for (int i = 3; i >= 0; i--) if (r[i]) win = i;
        resp = (l != 0) && (a == l) && (r != 0);
        exp_vec = (win >= 0) ? vbyte(l, r, win) : 8'h00;
        exp_g = (win >= 0) ? 4'(1 << win) : 4'h0;

        strap = 3'(l); src_req = 4'(r);
        for (int i = 0; i < 4; i++) src_vec[i*8 +: 8] = vbyte(l, r, i);
        step();
        exp_irq = 7'h7F;
        if (l != 0 && r != 0) exp_irq[l-1] = 1'b0;
        // R1 and R2: request line choice
        chk(irq_n == exp_irq, (l == 0) ? "R1 irq off" : "R2 irq line", 32'(irq_n), 32'(exp_irq));

        lvl_addr = 3'(a); iack_n = 1'b0; iackin_n = 1'b0; ds0_n = 1'b0;
        step();
        if (resp) begin
            chk(data_oe == 1'b1, "R4 oe", 32'(data_oe), 1);
            chk(data_out == exp_vec, "R4 R5 vector", 32'(data_out), 32'(exp_vec));
            chk(grant == exp_g, "R7 grant", 32'(grant), 32'(exp_g));
            chk(iackout_n == 1'b1, "R9 no pass", 32'(iackout_n), 1);
            // R5: change requests and vectors right after the start
            src_req = 4'hF;
            src_vec = ~src_vec;
            step();
            chk(dtack_n == 1'b0, "R6 dtack low", 32'(dtack_n), 0);
            chk(data_out == exp_vec, "R5 latched vector", 32'(data_out), 32'(exp_vec));
            chk(grant == 4'h0, "R7 grant one cycle", 32'(grant), 0);
            step();
            chk(dtack_n == 1'b0, "R6 dtack held", 32'(dtack_n), 0);
            ds0_n = 1'b1;
            step();
            chk(dtack_n == 1'b1 && data_oe == 1'b0, "R6 release",
                {dtack_n, data_oe}, 32'b10);
            // R9: second strobe while the chain input stays low
            ds0_n = 1'b0;
            step();
            step();
            chk(dtack_n == 1'b1 && data_oe == 1'b0 && iackout_n == 1'b1,
                "R9 no restart", {dtack_n, data_oe, iackout_n}, 32'b101);
        end else begin
            chk(iackout_n == 1'b0, (l == 0) ? "R1 pass" : "R8 pass", 32'(iackout_n), 0);
            chk(data_oe == 1'b0 && dtack_n == 1'b1, "R8 quiet",
                {data_oe, dtack_n}, 32'b01);
            step();
            chk(iackout_n == 1'b0, "R8 pass held", 32'(iackout_n), 0);
        end
        ds0_n = 1'b1; iackin_n = 1'b1; iack_n = 1'b1;
        step();
        chk(iackout_n == 1'b1, "R8 chain restored", 32'(iackout_n), 1);
        src_req = 4'h0;
        step();
        chk(irq_n == 7'h7F, "R3 release", 32'(irq_n), 32'h7F);
    endtask

    initial begin
        rst = 1'b1; strap = 3'd3; src_req = 4'hF; src_vec = '0;
        iack_n = 1'b1; iackin_n = 1'b1; ds0_n = 1'b1; lvl_addr = '0;
        step(); step();
        chk(irq_n == 7'h7F && iackout_n && dtack_n && !data_oe && grant == 0,
            "R10 reset", {irq_n, iackout_n, dtack_n, data_oe, grant}, {7'h7F, 3'b110, 4'h0});
        src_req = 4'h0;
        rst = 1'b0;
        step();
        chk(irq_n == 7'h7F && iackout_n && dtack_n && !data_oe,
            "R10 after reset", {irq_n, iackout_n, dtack_n, data_oe}, {7'h7F, 3'b110});
        for (int l = 0; l < 8; l++)
            for (int r = 0; r < 16; r++)
                for (int a = 0; a < 8; a++)
                    run_one(l, r, a);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule